// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the arbitration core of an eight-line interrupt controller. Each clock it samples eight request inputs and records them in a request register. A per-line trigger selection picks level capture or rising-edge capture for each line. Masked requests are dropped, and the best remaining request is found under a rotating priority order. That request is compared with the best line already in service. When it is strictly more urgent, the interrupt output is raised on the next clock.

The processor side answers with a one-cycle acknowledge pulse. On the following cycle the block returns the number of the winning line. In the same clock it marks that line as in service, drops edge-captured requests and, in automatic end-of-service operation, may rotate the priority origin. An outer command decoder owns the mask, the trigger selection, the operating flags, loads of the priority origin and the clearing of in-service bits. It drives them in as plain inputs.

Top module: `prio_irq_resolver`

## Requirements
- R1: For a line whose `trigLevel` bit is 1, the request bit after a clock edge equals the `reqLines` bit sampled at that edge. It is set while the input is high and cleared while it is low.
- R2: For a line whose `trigLevel` bit is 0, the request bit is set by a low-to-high change between two consecutive samples. A later return to low leaves the bit set.
- R3: Line n has priority index (n − origin) mod 8, and index 0 is the most urgent. The origin is 0 after reset and loads from `prioBase` in a cycle where `prioBaseLoad` is 1.
- R4: `irqOut` is 1 in the cycle after a clock edge exactly when, before that edge, the best index among set and unmasked requests was strictly smaller than the best index among in-service bits. An empty set counts as index 8.
- R5: With `IS_MASTER`=1 and `nestedMode`=1, in-service bit 2 is left out of the in-service index.
- R6: When `ackPulse` is 1 and a request wins, the next cycle shows `ackValid`=1 with `ackLine` set to the winning line. Unless `autoEoi` is 1, that line's in-service bit is set.
- R7: With `autoEoi`=1 an acknowledge sets no in-service bit. If `rotateOnAutoEoi` is also 1, the origin becomes (winning line + 1) mod 8. This takes precedence over a load in the same cycle.
- R8: An acknowledge clears the winning request bit only on an edge-mode line. A level-mode request stays set.
- R9: An acknowledge with no winning request returns `ackLine`=7 and changes no request, in-service or origin state.
- R10: Each 1 bit of `isrClear` clears the matching in-service bit at the clock edge. A set caused by an acknowledge in the same cycle takes effect after the clear.
- R11: A request whose `maskBits` bit is 1 takes no part in the search, and it keeps its request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLines | input | 8 | Raw interrupt request inputs |
| trigLevel | input | 8 | Per-line capture: 1 = level, 0 = rising edge |
| maskBits | input | 8 | Per-line mask, 1 = masked |
| prioBase | input | 3 | Priority origin value to load |
| prioBaseLoad | input | 1 | Load `prioBase` into the origin |
| autoEoi | input | 1 | Automatic end of service on acknowledge |
| rotateOnAutoEoi | input | 1 | Rotate the origin on an automatic end of service |
| nestedMode | input | 1 | Leave out in-service line 2 (master build only) |
| isrClear | input | 8 | Per-line in-service clear strobes |
| ackPulse | input | 1 | Interrupt acknowledge, one cycle |
| irqOut | output | 1 | Registered interrupt request |
| ackValid | output | 1 | Acknowledge answer valid |
| ackLine | output | 3 | Line returned for the acknowledge (7 when none wins) |

## Verification
The bench builds the block with the default `IS_MASTER`=1. This is the only setting in which `nestedMode` changes the in-service comparison, so the exclusion of line 2 can be driven both on and off in one run. A behavioural model of the request, in-service and origin state predicts `irqOut`, `ackValid` and `ackLine` on every clock. Directed sequences reach rotation, strict-priority blocking, spurious acknowledges and masking. A random phase then mixes trigger modes, flags and clears.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LINES     = 8;
  localparam int IDXW      = $clog2(LINES);
  localparam int CASC_LINE = 2;
  localparam int SPUR_LINE = LINES - 1;

  typedef struct packed {
    logic            ackFire;
    logic            setIsr;
    logic            clrIrr;
    logic            rotBase;
    logic [IDXW-1:0] line;
  } ackStrobe_t;

  // Best priority index of a vector under a rotated origin; LINES means none.
  function automatic logic [IDXW:0] bestIndex(input logic [LINES-1:0] vec,
                                              input logic [IDXW-1:0]  base);
    logic [IDXW:0]   res;
    logic [IDXW-1:0] pos;
    res = (IDXW+1)'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      pos = base + IDXW'(k);
      if (vec[pos]) res = (IDXW+1)'(k);
    end
    return res;
  endfunction
endpackage

// File: rtl/irq_control.sv
module irq_control
  import prio_irq_pkg::*;
(
  input  logic             ackPulse,
  input  logic             autoEoi,
  input  logic             rotateOnAutoEoi,
  input  logic [LINES-1:0] trigLevel,
  input  logic             winValid,
  input  logic [IDXW-1:0]  winLine,
  output ackStrobe_t       strobe
);
  logic takeWin;

  always_comb begin
    takeWin        = ackPulse && winValid;
    strobe.ackFire = ackPulse;
    strobe.line    = winValid ? winLine : IDXW'(SPUR_LINE);
    strobe.setIsr  = takeWin && !autoEoi;
    strobe.rotBase = takeWin && autoEoi && rotateOnAutoEoi;
    strobe.clrIrr  = takeWin && !trigLevel[winLine];
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import prio_irq_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqLines,
  input  logic [LINES-1:0] trigLevel,
  input  logic [LINES-1:0] maskBits,
  input  logic [IDXW-1:0]  prioBase,
  input  logic             prioBaseLoad,
  input  logic             nestedMode,
  input  logic [LINES-1:0] isrClear,
  input  ackStrobe_t       strobe,
  output logic             winValid,
  output logic [IDXW-1:0]  winLine,
  output logic             irqOut,
  output logic             ackValid,
  output logic [IDXW-1:0]  ackLine
);
  logic [LINES-1:0] irrQ, lastQ, isrQ;
  logic [IDXW-1:0]  baseQ;
  logic [LINES-1:0] isrView, lineOh, irrNext, isrNext, rising, irrKept;
  logic [IDXW:0]    reqIdx, isrIdx;

  generate
    if (IS_MASTER) begin : g_master
      always_comb begin
        isrView = isrQ;
        if (nestedMode) isrView[CASC_LINE] = 1'b0;
      end
    end else begin : g_slave
      always_comb isrView = isrQ;
    end
  endgenerate

  always_comb begin
    reqIdx   = bestIndex(irrQ & ~maskBits, baseQ);
    isrIdx   = bestIndex(isrView, baseQ);
    winValid = reqIdx < isrIdx;
    winLine  = reqIdx[IDXW-1:0] + baseQ;
    lineOh   = LINES'(1) << strobe.line;
    irrKept  = strobe.clrIrr ? (irrQ & ~lineOh) : irrQ;
    rising   = reqLines & ~lastQ;
    irrNext  = (trigLevel & reqLines) | (~trigLevel & (irrKept | rising));
    isrNext  = (isrQ & ~isrClear) | (strobe.setIsr ? lineOh : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ     <= '0;
      lastQ    <= '0;
      isrQ     <= '0;
      baseQ    <= '0;
      irqOut   <= 1'b0;
      ackValid <= 1'b0;
      ackLine  <= '0;
    end else begin
      irrQ     <= irrNext;
      lastQ    <= reqLines;
      isrQ     <= isrNext;
      irqOut   <= winValid;
      ackValid <= strobe.ackFire;
      if (strobe.ackFire) ackLine <= strobe.line;
      if (strobe.rotBase) baseQ <= strobe.line + IDXW'(1);
      else if (prioBaseLoad) baseQ <= prioBase;
    end
  end

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((irrQ & $past(trigLevel)) == ($past(reqLines) & $past(trigLevel)))); // R1
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.clrIrr) |-> ((($past(irrQ) & ~$past(trigLevel)) & ~irrQ) == '0)); // R2
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(irrQ & ~maskBits))); // R4
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.setIsr) |-> isrQ[$past(strobe.line)]); // R6
  AST_AUTO_EOI_NO_ISR: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.ackFire && !strobe.setIsr) |-> ((isrQ & ~$past(isrQ)) == '0)); // R7
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] reqLines,
  input  logic [7:0] trigLevel,
  input  logic [7:0] maskBits,
  input  logic [2:0] prioBase,
  input  logic       prioBaseLoad,
  input  logic       autoEoi,
  input  logic       rotateOnAutoEoi,
  input  logic       nestedMode,
  input  logic [7:0] isrClear,
  input  logic       ackPulse,
  output logic       irqOut,
  output logic       ackValid,
  output logic [2:0] ackLine
);
  ackStrobe_t      strobe;
  logic            winValid;
  logic [IDXW-1:0] winLine;

  irq_control u_ctrl (
    .ackPulse        (ackPulse),
    .autoEoi         (autoEoi),
    .rotateOnAutoEoi (rotateOnAutoEoi),
    .trigLevel       (trigLevel),
    .winValid        (winValid),
    .winLine         (winLine),
    .strobe          (strobe)
  );

  irq_datapath #(.IS_MASTER(IS_MASTER)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqLines     (reqLines),
    .trigLevel    (trigLevel),
    .maskBits     (maskBits),
    .prioBase     (prioBase),
    .prioBaseLoad (prioBaseLoad),
    .nestedMode   (nestedMode),
    .isrClear     (isrClear),
    .strobe       (strobe),
    .winValid     (winValid),
    .winLine      (winLine),
    .irqOut       (irqOut),
    .ackValid     (ackValid),
    .ackLine      (ackLine)
  );
endmodule

// File: tb/prio_irq_resolver_tb.sv
module prio_irq_resolver_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqLines = '0, trigLevel = '0, maskBits = '0, isrClear = '0;
  logic [2:0] prioBase = '0;
  logic       prioBaseLoad = 1'b0, autoEoi = 1'b0, rotateOnAutoEoi = 1'b0;
  logic       nestedMode = 1'b0, ackPulse = 1'b0;
  logic       irqOut, ackValid;
  logic [2:0] ackLine;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R4";

  prio_irq_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .trigLevel(trigLevel),
    .maskBits(maskBits), .prioBase(prioBase), .prioBaseLoad(prioBaseLoad),
    .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi), .nestedMode(nestedMode),
    .isrClear(isrClear), .ackPulse(ackPulse), .irqOut(irqOut),
    .ackValid(ackValid), .ackLine(ackLine));

  always #10 clk = ~clk;

  // Behavioural reference state
  bit [7:0] mIrr, mLast, mIsr, nIrr, nIsr, view;
  int       mBase, ri, ci, w, mAckL;
  bit       mIrq, mAckV, pend, rot;

  function automatic int best(bit [7:0] v, int b);
    for (int p = 0; p < 8; p++) if (v[(p + b) % 8]) return p;
    return 8;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mIrr = 0; mLast = 0; mIsr = 0; mBase = 0; mIrq = 0; mAckV = 0; mAckL = 0;
    end else begin
      view = mIsr;
      if (nestedMode) view[2] = 1'b0;
      ri   = best(mIrr & ~maskBits, mBase);
      ci   = best(view, mBase);
      pend = ri < ci;
      w    = (ri + mBase) % 8;
      nIrr = mIrr;
      nIsr = mIsr & ~isrClear;
      rot  = 0;
      mAckV = ackPulse;
      if (ackPulse) begin
        mAckL = pend ? w : 7;
        if (pend) begin
          if (!autoEoi) nIsr[w] = 1'b1;
          else if (rotateOnAutoEoi) rot = 1;
          if (!trigLevel[w]) nIrr[w] = 1'b0;
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (trigLevel[i]) nIrr[i] = reqLines[i];
        else if (reqLines[i] && !mLast[i]) nIrr[i] = 1'b1;
      end
      mLast = reqLines;
      if (rot) mBase = (w + 1) % 8;
      else if (prioBaseLoad) mBase = prioBase;
      mIrq = pend; mIrr = nIrr; mIsr = nIsr;
    end
    #5;
    check("irqOut", irqOut, mIrq);
    check("ackValid", ackValid, mAckV);
    if (mAckV) check("ackLine", ackLine, mAckL);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [7:0] m);
    reqLines = m; tick(1); reqLines = '0; tick(2);
  endtask

  task automatic ack();
    ackPulse = 1'b1; tick(1); ackPulse = 1'b0; tick(2);
  endtask

  task automatic clearAll();
    isrClear = 8'hff; tick(1); isrClear = '0; tick(1);
  endtask

  initial begin
    tick(3);
    curReq = "R4"; // reset state: no interrupt, no acknowledge
    rstN = 1'b1; tick(2);

    curReq = "R1"; trigLevel = 8'h08;
    reqLines = 8'h08; tick(3); reqLines = '0; tick(3);

    curReq = "R2"; trigLevel = '0;
    reqLines = 8'h20; tick(2); reqLines = '0; tick(3);
    curReq = "R8"; ack();
    trigLevel = 8'h08; reqLines = 8'h08; autoEoi = 1'b1; tick(2);
    ack(); tick(2);
    reqLines = '0; autoEoi = 1'b0; trigLevel = '0; tick(2); clearAll();

    curReq = "R6"; pulse(8'h08); ack();
    curReq = "R4"; pulse(8'h20); tick(2); pulse(8'h02); ack();
    clearAll(); ack(); clearAll();

    curReq = "R3"; prioBase = 3'd4; prioBaseLoad = 1'b1; tick(1); prioBaseLoad = 1'b0;
    pulse(8'h42); ack(); ack(); clearAll();
    prioBase = 3'd0; prioBaseLoad = 1'b1; tick(1); prioBaseLoad = 1'b0;

    curReq = "R5"; pulse(8'h04); ack(); pulse(8'h10);
    nestedMode = 1'b0; tick(3); nestedMode = 1'b1; tick(3); ack();
    nestedMode = 1'b0; clearAll();

    curReq = "R7"; autoEoi = 1'b1; rotateOnAutoEoi = 1'b1;
    pulse(8'h20); ack(); pulse(8'h60); ack(); ack();
    autoEoi = 1'b0; rotateOnAutoEoi = 1'b0;

    curReq = "R9"; ack(); ack(); tick(2);

    curReq = "R10"; pulse(8'h01); ack(); pulse(8'h10); tick(2);
    isrClear = 8'h01; tick(1); isrClear = '0; tick(2); ack(); clearAll();

    curReq = "R11"; maskBits = 8'h10; pulse(8'h10); tick(2);
    maskBits = '0; tick(3); ack(); clearAll();

    curReq = "mixed R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11";
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        trigLevel = 8'($urandom); autoEoi = 1'($urandom); rotateOnAutoEoi = 1'($urandom);
        nestedMode = 1'($urandom); maskBits = 8'($urandom) & 8'($urandom);
      end
      reqLines     = 8'($urandom) & 8'($urandom);
      ackPulse     = ($urandom % 4) == 0;
      isrClear     = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      prioBaseLoad = ($urandom % 16) == 0;
      prioBase     = 3'($urandom);
      tick(1);
    end
    ackPulse = 1'b0; prioBaseLoad = 1'b0; isrClear = '0; tick(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog %s: actual running expected done", curReq);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule